// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block keeps the raw interrupt status of a serial port and turns it into interrupt request lines. Eleven event sources each deliver a one-cycle set pulse, and the matching status bit latches until software clears it. The event sources are receive, transmit, receive timeout, four modem lines and four receive error kinds. A mask register, written from the bus side, selects which status bits may reach the interrupt outputs.

The bus side writes the mask and clears status bits by writing ones. It reads raw and masked status straight from two output vectors, and such reads have no side effects. Six registered request lines are driven from the masked status. One line combines every source. The other five are a receive line, a transmit line, a timeout line, a merged modem line and a merged error line. Address decoding, event generation and the serial line logic belong to the neighbouring blocks.

Top module: `uart_irq_router`

## Requirements
- R1: A 1 on set_i[k] for one cycle makes raw_o[k] 1, and it stays 1 until cleared. The bit map is: ring indicator 0, clear-to-send 1, carrier detect 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break error 9, overrun 10.
- R2: masked_o always equals raw_o ANDed with the last value written through mask_we_i/mask_wdata_i.
- R3: A cycle with clr_we_i high clears every raw_o bit whose clr_wdata_i bit is 1. Every other bit keeps its value.
- R4: When set_i[k] and a clear of bit k happen in the same cycle, raw_o[k] ends up 1.
- R5: irq_all_o is 1 exactly when any bit of masked_o is 1.
- R6: irq_err_o is 1 exactly when any of masked_o bits 7, 8, 9 or 10 is 1.
- R7: irq_ms_o is 1 exactly when any of masked_o bits 0, 1, 2 or 3 is 1.
- R8: irq_rx_o, irq_tx_o and irq_rt_o each follow only masked_o bit 4, 5 and 6 respectively.
- R9: A mask write updates masked_o and all request lines, and it leaves raw_o unchanged.
- R10: After reset, raw_o, masked_o and all six request lines are 0.
- R11: Every output changes at the first clock edge after the set pulse, clear write or mask write that causes it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 11 | Per-source set pulses |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 11 | Mask write data |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_wdata_i | input | 11 | Clear data, 1 clears the bit |
| raw_o | output | 11 | Raw status |
| masked_o | output | 11 | Raw status ANDed with mask |
| irq_all_o | output | 1 | Combined request |
| irq_rx_o | output | 1 | Receive request |
| irq_tx_o | output | 1 | Transmit request |
| irq_rt_o | output | 1 | Receive timeout request |
| irq_ms_o | output | 1 | Modem line request |
| irq_err_o | output | 1 | Receive error request |

## Verification
Each source is first set alone with the mask fully open. This separates the eleven bit positions and shows which request line each one drives. Walking single-bit masks over a full raw status then checks that the error and modem groups merge exactly their four bits, and nothing else. Collision cycles, where a set and a clear hit the same bit, separate set-priority from clear-priority. Mixed random sets, clears and mask writes compared on every clock expose stale or early outputs.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned NUM_SRC = 11;
  localparam int unsigned NUM_GRP = 6;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // group indices into the request vector
  localparam int unsigned GRP_ALL = 0;
  localparam int unsigned GRP_RX  = 1;
  localparam int unsigned GRP_TX  = 2;
  localparam int unsigned GRP_RT  = 3;
  localparam int unsigned GRP_MS  = 4;
  localparam int unsigned GRP_ERR = 5;

  localparam src_vec_t SRC_MODEM = 11'h00F;
  localparam src_vec_t SRC_RX    = 11'h010;
  localparam src_vec_t SRC_TX    = 11'h020;
  localparam src_vec_t SRC_RT    = 11'h040;
  localparam src_vec_t SRC_ERR   = 11'h780;

  function automatic src_vec_t grp_mask(int unsigned g);
    case (g)
      GRP_ALL: grp_mask = SRC_MODEM | SRC_RX | SRC_TX | SRC_RT | SRC_ERR;
      GRP_RX:  grp_mask = SRC_RX;
      GRP_TX:  grp_mask = SRC_TX;
      GRP_RT:  grp_mask = SRC_RT;
      GRP_MS:  grp_mask = SRC_MODEM;
      default: grp_mask = SRC_ERR;
    endcase
  endfunction
endpackage

// File: rtl/uirq_status_reg.sv
module uirq_status_reg
  import uirq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t set_i,
  input  logic     clr_we_i,
  input  src_vec_t clr_wdata_i,
  output src_vec_t raw_d_o,
  output src_vec_t raw_q_o
);
  src_vec_t clr_vec;
  src_vec_t raw_q;

  assign clr_vec = clr_we_i ? clr_wdata_i : '0;
  // set has priority over clear on the same bit
  assign raw_d_o = (raw_q & ~clr_vec) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_d_o;
  end

  assign raw_q_o = raw_q;
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
  import uirq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  src_vec_t wdata_i,
  output src_vec_t mask_d_o,
  output src_vec_t mask_q_o
);
  src_vec_t mask_q;

  assign mask_d_o = we_i ? wdata_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d_o;
  end

  assign mask_q_o = mask_q;
endmodule

// File: rtl/uirq_route.sv
module uirq_route
  import uirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  src_vec_t           raw_d_i,
  input  src_vec_t           mask_d_i,
  output src_vec_t           masked_o,
  output logic [NUM_GRP-1:0] irq_o
);
  src_vec_t masked_d;
  src_vec_t masked_q;

  // registered from next-state so outputs align with raw status
  assign masked_d = raw_d_i & mask_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) masked_q <= '0;
    else         masked_q <= masked_d;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam src_vec_t GM = grp_mask(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[g] <= 1'b0;
      else         irq_o[g] <= |(masked_d & GM);
    end
  end

  assign masked_o = masked_q;
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import uirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_wdata_i,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] masked_o,
  output logic               irq_all_o,
  output logic               irq_rx_o,
  output logic               irq_tx_o,
  output logic               irq_rt_o,
  output logic               irq_ms_o,
  output logic               irq_err_o
);
  src_vec_t           raw_d, raw_q, mask_d, mask_q;
  logic [NUM_GRP-1:0] irq;

  uirq_status_reg u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_i),
    .clr_we_i    (clr_we_i),
    .clr_wdata_i (clr_wdata_i),
    .raw_d_o     (raw_d),
    .raw_q_o     (raw_q)
  );

  uirq_mask_reg u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mask_we_i),
    .wdata_i  (mask_wdata_i),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q)
  );

  uirq_route u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_d_i  (raw_d),
    .mask_d_i (mask_d),
    .masked_o (masked_o),
    .irq_o    (irq)
  );

  assign raw_o     = raw_q;
  assign irq_all_o = irq[GRP_ALL];
  assign irq_rx_o  = irq[GRP_RX];
  assign irq_tx_o  = irq[GRP_TX];
  assign irq_rt_o  = irq[GRP_RT];
  assign irq_ms_o  = irq[GRP_MS];
  assign irq_err_o = irq[GRP_ERR];
endmodule

// File: rtl/uart_irq_router_chk.sv
module uart_irq_router_chk
  import uirq_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input src_vec_t set_i,
  input logic     mask_we_i,
  input logic     clr_we_i,
  input src_vec_t clr_wdata_i,
  input src_vec_t raw_o,
  input src_vec_t masked_o,
  input src_vec_t mask_q,
  input logic     irq_all_o,
  input logic     irq_ms_o,
  input logic     irq_err_o
);
  // R1
  set_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((raw_o & $past(set_i)) == $past(set_i)));
  // R3
  clr_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((raw_o & $past(clr_wdata_i & ~set_i)) == '0));
  // R2
  masked_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_o == (raw_o & mask_q));
  // R5
  all_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_all_o == (|masked_o));
  // R6
  err_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o == (|masked_o[10:7]));
  // R7
  ms_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ms_o == (|masked_o[3:0]));
  // R9
  mask_keeps_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && !clr_we_i && set_i == '0) |=> $stable(raw_o));
endmodule

bind uart_irq_router uart_irq_router_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .set_i       (set_i),
  .mask_we_i   (mask_we_i),
  .clr_we_i    (clr_we_i),
  .clr_wdata_i (clr_wdata_i),
  .raw_o       (raw_o),
  .masked_o    (masked_o),
  .mask_q      (mask_q),
  .irq_all_o   (irq_all_o),
  .irq_ms_o    (irq_ms_o),
  .irq_err_o   (irq_err_o)
);

// File: tb/uart_irq_router_tb_top.sv
module uart_irq_router_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] set_i = '0, mask_wdata_i = '0, clr_wdata_i = '0;
  logic        mask_we_i = 1'b0, clr_we_i = 1'b0;
  logic [10:0] raw_o, masked_o;
  logic        irq_all_o, irq_rx_o, irq_tx_o, irq_rt_o, irq_ms_o, irq_err_o;

  int errors = 0;
  int checks = 0;
  int m_raw = 0;
  int m_mask = 0;

  always #10 clk_i = ~clk_i;

  uart_irq_router dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
    .raw_o(raw_o), .masked_o(masked_o),
    .irq_all_o(irq_all_o), .irq_rx_o(irq_rx_o), .irq_tx_o(irq_tx_o),
    .irq_rt_o(irq_rt_o), .irq_ms_o(irq_ms_o), .irq_err_o(irq_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_of(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  task automatic compare_all(input string tag);
    int m;
    m = m_raw & m_mask;
    chk({tag, " R1/R3/R4 raw"}, int'(raw_o), m_raw);
    chk({tag, " R2 masked"}, int'(masked_o), m);
    chk({tag, " R5 all"}, int'(irq_all_o), int'(m != 0));
    chk({tag, " R6 err"}, int'(irq_err_o),
        bit_of(m,7) | bit_of(m,8) | bit_of(m,9) | bit_of(m,10));
    chk({tag, " R7 ms"}, int'(irq_ms_o),
        bit_of(m,0) | bit_of(m,1) | bit_of(m,2) | bit_of(m,3));
    chk({tag, " R8 rx"}, int'(irq_rx_o), bit_of(m,4));
    chk({tag, " R8 tx"}, int'(irq_tx_o), bit_of(m,5));
    chk({tag, " R8 rt"}, int'(irq_rt_o), bit_of(m,6));
  endtask

  // one cycle: drive at negedge, model updates at edge, compare at next negedge
  task automatic cyc(input string tag, input int s, input bit mw, input int mv,
                     input bit cw, input int cv);
    int old_raw;
    int old_masked;
    set_i = s[10:0]; mask_we_i = mw; mask_wdata_i = mv[10:0];
    clr_we_i = cw; clr_wdata_i = cv[10:0];
    old_raw = m_raw;
    old_masked = m_raw & m_mask;
    #5;
    // R11: nothing moves before the edge
    chk({tag, " R11 raw early"}, int'(raw_o), old_raw);
    chk({tag, " R11 masked early"}, int'(masked_o), old_masked);
    @(posedge clk_i);
    if (cw) m_raw = m_raw & ~cv;
    m_raw = (m_raw | s) & 'h7FF;
    if (mw) m_mask = mv & 'h7FF;
    @(negedge clk_i);
    set_i = '0; mask_we_i = 1'b0; clr_we_i = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare_all("reset R10");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("post-reset R10");

    // R1 / R8: each source alone, mask open
    cyc("open mask R2", 0, 1, 'h7FF, 0, 0);
    for (int b = 0; b < 11; b++) begin
      cyc("single set R1", 1 << b, 0, 0, 0, 0);
      cyc("clear one R3", 0, 0, 0, 1, 1 << b);
    end

    // R6/R7: full raw, walking single-bit masks
    cyc("fill R1", 'h7FF, 0, 0, 0, 0);
    for (int b = 0; b < 11; b++)
      cyc("walk mask R9", 0, 1, 1 << b, 0, 0);
    cyc("mask off R9", 0, 1, 0, 0, 0);
    cyc("mask err R6", 0, 1, 'h780, 0, 0);
    cyc("mask ms R7", 0, 1, 'h00F, 0, 0);

    // R3: partial clear keeps the rest
    cyc("open R2", 0, 1, 'h7FF, 0, 0);
    cyc("partial clr R3", 0, 0, 0, 1, 'h555);
    cyc("clr none R3", 0, 0, 0, 1, 0);

    // R4: collision, set wins
    cyc("collide R4", 'h081, 0, 0, 1, 'h7FF);
    chk("R4 collide bits", int'(raw_o), 'h081);
    cyc("collide2 R4", 'h400, 1, 'h400, 1, 'h400);

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom);
      cyc("random", (r & 7) == 0 ? int'($urandom) & 'h7FF : 0,
          (r & 'h30) == 0, int'($urandom) & 'h7FF,
          (r & 'h300) == 0, int'($urandom) & 'h7FF);
    end

    // R10: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_raw = 0; m_mask = 0;
    #5;
    compare_all("async reset R10");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("after reset R10");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule